// File: doc/BRIEF.md
# Panel Command-Bus Write Engine

This block lets a host processor talk to a parallel-bus LCD panel through a handful of word registers. It sends index (command) writes, data writes and data reads to either of two panel channels. The host loads a 32-bit write word, or a read-request word, into a register. It polls a busy flag until the flag reads 0. It then writes a trigger register, which starts the transfer and names the target channel.

The engine runs a generic 8080-style strobe sequence on a 16-bit panel bus. A bus cycle has three phases: setup, strobe and hold. Each phase lasts a programmable number of clocks. During a cycle only the chosen channel's chip-select is active. Read data is captured on the last clock of the strobe phase, and the host reads it back later.

Host register addresses (word index on `reg_addr`):

| Address | Register |
|---|---|
| 0 | write word |
| 1 | read request when written; read result when read |
| 2 | write trigger |
| 3 | read trigger |
| 4 | status |
| 5 | timing |

Top module: `lcd_cmdbus_engine`

## Requirements
- R1: While reset is held, and after it is released with no host activity, both chip-selects are high (inactive) and both strobes are high. The output enable is low and the register-select line is low. The status register (address 4) reads 0 and the read result (address 1) reads 0.
- R2: A write trigger starts a write cycle only when the panel is idle and the stored write word has bit 28 set. A write trigger is a write to address 2 with bit 0 set. During the cycle the register-select line equals bit 24 of the word: 0 gives an index cycle and 1 gives a data cycle.
- R3: Bit 1 of the accepted trigger word picks the channel: 0 picks channel 0 (main) and 1 picks channel 1 (sub). Only that channel's chip-select (`pnl_cs_n[0]` or `pnl_cs_n[1]`) is driven low, and it stays low for the whole cycle. The other chip-select stays high.
- R4: The timing register (address 5) holds three counts: setup in bits 3:0, strobe in bits 11:8 and hold in bits 19:16. A cycle lasts setup+1 clocks, then strobe+1 clocks with the strobe low, then hold+1 clocks. The chip-select is active in all three phases. The counts are taken at the moment the trigger is accepted. Reading address 5 returns these three fields, with all other bits 0.
- R5: Status bit 1 (busy) reads 1 from the cycle after an accepted trigger through the last hold clock, which is setup+strobe+hold+3 cycles in total. Every other status bit is 0.
- R6: A trigger written while busy reads 1 is ignored, including a trigger on the final hold clock.
- R7: A trigger is also ignored in any of these cases: bit 0 of the trigger word is clear; it is a write trigger and the stored write word has bit 28 clear; it is a read trigger and the stored read-request word has bit 24 clear.
- R8: A read trigger (address 3, bit 0 set, with the read-request word bit 24 set) starts a read cycle. During the strobe phase `pnl_rd_n` is low instead of `pnl_wr_n`. The register-select line is high and the output enable stays low for the whole cycle.
- R9: During a read, `pnl_din` is sampled on the last strobe clock. From the next cycle, address 1 reads that value in bits 15:0 with bits 31:16 zero. The value is kept until the next read completes.
- R10: During a write cycle the output enable is high for all three phases. `pnl_dout` carries bits 15:0 of the write word as it stood when the trigger was accepted; rewriting address 0 during the cycle does not change the pins. When the output enable is low, `pnl_dout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Host register write strobe |
| reg_addr | input | 3 | Host register word address |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data for `reg_addr` (combinational) |
| pnl_din | input | 16 | Panel data bus input |
| pnl_cs_n | output | 2 | Per-channel chip-selects, active low |
| pnl_rs | output | 1 | Register-select: 0 index, 1 data |
| pnl_wr_n | output | 1 | Write strobe, active low |
| pnl_rd_n | output | 1 | Read strobe, active low |
| pnl_dout | output | 16 | Panel data bus output |
| pnl_doe | output | 1 | Panel data bus output enable |

## Verification
Two events can land on the same clock: the end of the hold phase and a new trigger. The bench uses its reference model to place a trigger exactly on the final hold clock, where the trigger must be dropped. It then places another trigger on the first idle clock, where the trigger must start a fresh cycle. The second collision is a host rewrite of the write word or the timing register in the middle of a cycle, which must not disturb the pins. The panel input changes on every clock, so the read result shows which clock was sampled. Every clock, the pins and the register read data are compared with a behavioural model.

// File: rtl/lcd_cmdbus_pkg.sv
package lcd_cmdbus_pkg;

  // Bus cycle phase
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;

  // Host register map (word addresses)
  localparam int unsigned REG_AW = 3;
  localparam logic [REG_AW-1:0] A_WWORD = 3'd0;
  localparam logic [REG_AW-1:0] A_RWORD = 3'd1;
  localparam logic [REG_AW-1:0] A_WTRIG = 3'd2;
  localparam logic [REG_AW-1:0] A_RTRIG = 3'd3;
  localparam logic [REG_AW-1:0] A_STAT  = 3'd4;
  localparam logic [REG_AW-1:0] A_TIME  = 3'd5;

  // Bit positions
  localparam int unsigned TAG_VALID_BIT = 28;
  localparam int unsigned TAG_DATA_BIT  = 24;
  localparam int unsigned TRIG_GO_BIT   = 0;
  localparam int unsigned TRIG_SUB_BIT  = 1;
  localparam int unsigned STAT_BUSY_BIT = 1;
  localparam int unsigned TIM_SETUP_LSB = 0;
  localparam int unsigned TIM_PULSE_LSB = 8;
  localparam int unsigned TIM_HOLD_LSB  = 16;

  localparam int unsigned NUM_CH = 2;

endpackage

// File: rtl/lcd_cmdbus_regs.sv
module lcd_cmdbus_regs
  import lcd_cmdbus_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              busy,
  input  logic [DATA_W-1:0] rd_result,
  output logic [31:0]       reg_rdata,
  output logic              start,
  output logic              start_rd,
  output logic              start_sub,
  output logic              w_rs,
  output logic [DATA_W-1:0] w_data,
  output logic [CNT_W-1:0]  tm_setup,
  output logic [CNT_W-1:0]  tm_pulse,
  output logic [CNT_W-1:0]  tm_hold
);

  // Stored state: only the bits the engine acts on
  logic              wvalid_q, wvalid_d;
  logic              wrs_q,    wrs_d;
  logic [DATA_W-1:0] wdat_q,   wdat_d;
  logic              rreq_q,   rreq_d;
  logic [CNT_W-1:0]  set_q, set_d, pul_q, pul_d, hld_q, hld_d;

  logic we_word, we_rreq, we_time, go_bit;
  logic unused_wbits;

  assign unused_wbits = ^reg_wdata;

  assign we_word = reg_we && (reg_addr == A_WWORD);
  assign we_rreq = reg_we && (reg_addr == A_RWORD);
  assign we_time = reg_we && (reg_addr == A_TIME);
  assign go_bit  = reg_wdata[TRIG_GO_BIT];

  // Trigger decode
  always_comb begin
    start_rd  = 1'b0;
    start     = 1'b0;
    start_sub = reg_wdata[TRIG_SUB_BIT];
    if (reg_we && go_bit && !busy) begin
      if ((reg_addr == A_WTRIG) && wvalid_q) begin
        start = 1'b1;
      end else if ((reg_addr == A_RTRIG) && rreq_q) begin
        start    = 1'b1;
        start_rd = 1'b1;
      end
    end
  end

  // Next state
  always_comb begin
    wvalid_d = wvalid_q;
    wrs_d    = wrs_q;
    wdat_d   = wdat_q;
    rreq_d   = rreq_q;
    set_d    = set_q;
    pul_d    = pul_q;
    hld_d    = hld_q;
    if (we_word) begin
      wvalid_d = reg_wdata[TAG_VALID_BIT];
      wrs_d    = reg_wdata[TAG_DATA_BIT];
      wdat_d   = reg_wdata[DATA_W-1:0];
    end
    if (we_rreq) begin
      rreq_d = reg_wdata[TAG_DATA_BIT];
    end
    if (we_time) begin
      set_d = reg_wdata[TIM_SETUP_LSB +: CNT_W];
      pul_d = reg_wdata[TIM_PULSE_LSB +: CNT_W];
      hld_d = reg_wdata[TIM_HOLD_LSB  +: CNT_W];
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wvalid_q <= 1'b0;
      wrs_q    <= 1'b0;
      wdat_q   <= '0;
      rreq_q   <= 1'b0;
      set_q    <= '0;
      pul_q    <= '0;
      hld_q    <= '0;
    end else begin
      if (we_word) begin
        wvalid_q <= wvalid_d;
        wrs_q    <= wrs_d;
        wdat_q   <= wdat_d;
      end
      if (we_rreq) begin
        rreq_q <= rreq_d;
      end
      if (we_time) begin
        set_q <= set_d;
        pul_q <= pul_d;
        hld_q <= hld_d;
      end
    end
  end

  assign w_rs     = wrs_q;
  assign w_data   = wdat_q;
  assign tm_setup = set_q;
  assign tm_pulse = pul_q;
  assign tm_hold  = hld_q;

  // Read mux
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_RWORD: reg_rdata[DATA_W-1:0] = rd_result;
      A_STAT:  reg_rdata[STAT_BUSY_BIT] = busy;
      A_TIME: begin
        reg_rdata[TIM_SETUP_LSB +: CNT_W] = set_q;
        reg_rdata[TIM_PULSE_LSB +: CNT_W] = pul_q;
        reg_rdata[TIM_HOLD_LSB  +: CNT_W] = hld_q;
      end
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/lcd_cmdbus_seq.sv
module lcd_cmdbus_seq
  import lcd_cmdbus_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_rd,
  input  logic             start_sub,
  input  logic [CNT_W-1:0] tm_setup,
  input  logic [CNT_W-1:0] tm_pulse,
  input  logic [CNT_W-1:0] tm_hold,
  output phase_e           phase,
  output logic             busy,
  output logic             last_strobe,
  output logic             is_rd,
  output logic             sub
);

  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] pul_q, pul_d, hld_q, hld_d;
  logic             rd_q, rd_d, sub_q, sub_d;
  logic             cnt_zero, adv;

  assign cnt_zero = (cnt_q == '0);
  assign adv      = (ph_q != PH_IDLE) || start;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    pul_d = pul_q;
    hld_d = hld_q;
    rd_d  = rd_q;
    sub_d = sub_q;
    case (ph_q)
      PH_IDLE: begin
        if (start) begin
          ph_d  = PH_SETUP;
          cnt_d = tm_setup;
          pul_d = tm_pulse;
          hld_d = tm_hold;
          rd_d  = start_rd;
          sub_d = start_sub;
        end
      end
      PH_SETUP: begin
        if (cnt_zero) begin
          ph_d  = PH_STROBE;
          cnt_d = pul_q;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_STROBE: begin
        if (cnt_zero) begin
          ph_d  = PH_HOLD;
          cnt_d = hld_q;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_HOLD: begin
        if (cnt_zero) begin
          ph_d = PH_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      pul_q <= '0;
      hld_q <= '0;
      rd_q  <= 1'b0;
      sub_q <= 1'b0;
    end else if (adv) begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      pul_q <= pul_d;
      hld_q <= hld_d;
      rd_q  <= rd_d;
      sub_q <= sub_d;
    end
  end

  assign phase       = ph_q;
  assign busy        = (ph_q != PH_IDLE);
  assign last_strobe = (ph_q == PH_STROBE) && cnt_zero;
  assign is_rd       = rd_q;
  assign sub         = sub_q;

endmodule

// File: rtl/lcd_cmdbus_pins.sv
module lcd_cmdbus_pins
  import lcd_cmdbus_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_rd,
  input  logic              w_rs,
  input  logic [DATA_W-1:0] w_data,
  input  phase_e            phase,
  input  logic              is_rd,
  input  logic              sub,
  input  logic              last_strobe,
  input  logic [DATA_W-1:0] pnl_din,
  output logic [NUM_CH-1:0] pnl_cs_n,
  output logic              pnl_rs,
  output logic              pnl_wr_n,
  output logic              pnl_rd_n,
  output logic [DATA_W-1:0] pnl_dout,
  output logic              pnl_doe,
  output logic [DATA_W-1:0] rd_result
);

  logic              rs_q, rs_d;
  logic [DATA_W-1:0] dat_q, dat_d;
  logic [DATA_W-1:0] res_q, res_d;
  logic              active, strobe, cap_en;

  assign active = (phase != PH_IDLE);
  assign strobe = (phase == PH_STROBE);
  assign cap_en = last_strobe && is_rd;

  always_comb begin
    rs_d  = start_rd | w_rs;
    dat_d = w_data;
    res_d = pnl_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q  <= 1'b0;
      dat_q <= '0;
      res_q <= '0;
    end else begin
      if (start) begin
        rs_q  <= rs_d;
        dat_q <= dat_d;
      end
      if (cap_en) begin
        res_q <= res_d;
      end
    end
  end

  // Per-channel chip-selects
  for (genvar g = 0; g < NUM_CH; g++) begin : g_cs
    assign pnl_cs_n[g] = !(active && (sub == 1'(g)));
  end

  assign pnl_rs    = active && rs_q;
  assign pnl_wr_n  = !(strobe && !is_rd);
  assign pnl_rd_n  = !(strobe && is_rd);
  assign pnl_doe   = active && !is_rd;
  assign pnl_dout  = pnl_doe ? dat_q : '0;
  assign rd_result = res_q;

endmodule

// File: rtl/lcd_cmdbus_engine.sv
module lcd_cmdbus_engine
  import lcd_cmdbus_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [DATA_W-1:0] pnl_din,
  output logic [NUM_CH-1:0] pnl_cs_n,
  output logic              pnl_rs,
  output logic              pnl_wr_n,
  output logic              pnl_rd_n,
  output logic [DATA_W-1:0] pnl_dout,
  output logic              pnl_doe
);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_q = rst_sync[1];

  logic              busy, start, start_rd, start_sub, w_rs;
  logic              last_strobe, is_rd, sub;
  logic [DATA_W-1:0] w_data, rd_result;
  logic [CNT_W-1:0]  tm_setup, tm_pulse, tm_hold;
  phase_e            phase;

  lcd_cmdbus_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_q),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .busy      (busy),
    .rd_result (rd_result),
    .reg_rdata (reg_rdata),
    .start     (start),
    .start_rd  (start_rd),
    .start_sub (start_sub),
    .w_rs      (w_rs),
    .w_data    (w_data),
    .tm_setup  (tm_setup),
    .tm_pulse  (tm_pulse),
    .tm_hold   (tm_hold)
  );

  lcd_cmdbus_seq #(.CNT_W(CNT_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_q),
    .start       (start),
    .start_rd    (start_rd),
    .start_sub   (start_sub),
    .tm_setup    (tm_setup),
    .tm_pulse    (tm_pulse),
    .tm_hold     (tm_hold),
    .phase       (phase),
    .busy        (busy),
    .last_strobe (last_strobe),
    .is_rd       (is_rd),
    .sub         (sub)
  );

  lcd_cmdbus_pins #(.DATA_W(DATA_W)) u_pins (
    .clk         (clk),
    .rst_n       (rst_q),
    .start       (start),
    .start_rd    (start_rd),
    .w_rs        (w_rs),
    .w_data      (w_data),
    .phase       (phase),
    .is_rd       (is_rd),
    .sub         (sub),
    .last_strobe (last_strobe),
    .pnl_din     (pnl_din),
    .pnl_cs_n    (pnl_cs_n),
    .pnl_rs      (pnl_rs),
    .pnl_wr_n    (pnl_wr_n),
    .pnl_rd_n    (pnl_rd_n),
    .pnl_dout    (pnl_dout),
    .pnl_doe     (pnl_doe),
    .rd_result   (rd_result)
  );

endmodule

// File: rtl/lcd_cmdbus_chk.sv
module lcd_cmdbus_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_q,
  input logic              busy,
  input logic              start,
  input logic [1:0]        cs_n,
  input logic              wr_n,
  input logic              rd_n,
  input logic              doe,
  input logic [DATA_W-1:0] rd_result
);

  // R3: never more than one chip-select active
  p_one_cs_r3: assert property (@(posedge clk) disable iff (!rst_n || !rst_q)
    $countones(~cs_n) <= 1);

  // R3: exactly one chip-select while busy, unchanged through the cycle
  p_busy_cs_r3: assert property (@(posedge clk) disable iff (!rst_n || !rst_q)
    busy |-> ($countones(~cs_n) == 1));

  p_cs_stable_r3: assert property (@(posedge clk) disable iff (!rst_n || !rst_q)
    (busy && $past(busy)) |-> $stable(cs_n));

  // R5: busy follows an accepted trigger
  p_busy_rise_r5: assert property (@(posedge clk) disable iff (!rst_n || !rst_q)
    start |=> busy);

  // R5: idle bus is quiet
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n || !rst_q)
    !busy |-> (cs_n == 2'b11 && wr_n && rd_n && !doe));

  // R4: a strobe only appears under an active chip-select
  p_strobe_cs_r4: assert property (@(posedge clk) disable iff (!rst_n || !rst_q)
    (!wr_n || !rd_n) |-> (cs_n != 2'b11));

  // R8: read strobe excludes write strobe and output enable
  p_read_excl_r8: assert property (@(posedge clk) disable iff (!rst_n || !rst_q)
    !rd_n |-> (wr_n && !doe));

  // R9: read result changes only right after a read strobe clock
  p_capture_r9: assert property (@(posedge clk) disable iff (!rst_n || !rst_q)
    !$stable(rd_result) |-> $past(!rd_n));

endmodule

bind lcd_cmdbus_engine lcd_cmdbus_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rst_q     (rst_q),
  .busy      (busy),
  .start     (start),
  .cs_n      (pnl_cs_n),
  .wr_n      (pnl_wr_n),
  .rd_n      (pnl_rd_n),
  .doe       (pnl_doe),
  .rd_result (rd_result)
);

// File: tb/lcd_cmdbus_engine_tb.sv
module lcd_cmdbus_engine_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd4;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic [15:0] pnl_din = 16'd0;
  logic [1:0]  pnl_cs_n;
  logic        pnl_rs, pnl_wr_n, pnl_rd_n, pnl_doe;
  logic [15:0] pnl_dout;

  int n_vec = 0;
  int n_bad = 0;
  int cyc   = 0;
  logic [2:0] idle_addr = 3'd4;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_cmdbus_engine u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pnl_din(pnl_din),
    .pnl_cs_n(pnl_cs_n), .pnl_rs(pnl_rs), .pnl_wr_n(pnl_wr_n),
    .pnl_rd_n(pnl_rd_n), .pnl_dout(pnl_dout), .pnl_doe(pnl_doe)
  );

  // ---------------- reference model ----------------
  bit          m_act = 0;
  int          m_t = 0, m_S = 0, m_P = 0, m_H = 0;
  bit          m_rd = 0, m_ch = 0, m_rs = 0;
  logic [15:0] m_dat = 0, m_rres = 0;
  logic [31:0] m_wword = 0, m_rreq = 0, m_tim = 0;

  always @(posedge clk) begin
    bit was_busy;
    cyc = cyc + 1;
    if (!rst_n) begin
      m_act = 0; m_t = 0; m_rres = 0; m_wword = 0; m_rreq = 0; m_tim = 0;
      m_rd = 0; m_ch = 0; m_rs = 0; m_dat = 0;
    end else begin
      was_busy = m_act;
      if (m_act) begin
        if (m_rd && m_t == m_S + m_P + 1) m_rres = pnl_din;
        if (m_t == m_S + m_P + m_H + 2) m_act = 0;
        else m_t = m_t + 1;
      end
      if (reg_we) begin
        case (reg_addr)
          3'd0: m_wword = reg_wdata;
          3'd1: m_rreq = reg_wdata;
          3'd5: m_tim = reg_wdata & 32'h000F_0F0F;
          3'd2, 3'd3: begin
            if (!was_busy && reg_wdata[0] &&
                ((reg_addr == 3'd2 && m_wword[28]) || (reg_addr == 3'd3 && m_rreq[24]))) begin
              m_act = 1; m_t = 0;
              m_S = int'(m_tim[3:0]); m_P = int'(m_tim[11:8]); m_H = int'(m_tim[19:16]);
              m_ch = reg_wdata[1];
              m_rd = (reg_addr == 3'd3);
              m_rs = m_rd ? 1'b1 : m_wword[24];
              m_dat = m_wword[15:0];
            end
          end
          default: ;
        endcase
      end
    end
  end

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual %h expected %h", tag, what, cyc, act, exp);
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) begin
    bit strobe;
    logic [1:0] e_cs;
    logic [31:0] e_rd;
    strobe = m_act && (m_t >= m_S + 1) && (m_t <= m_S + m_P + 1);
    e_cs = m_act ? (m_ch ? 2'b01 : 2'b10) : 2'b11;
    case (reg_addr)
      3'd1: e_rd = {16'd0, m_rres};
      3'd4: e_rd = {30'd0, m_act, 1'b0};
      3'd5: e_rd = m_tim;
      default: e_rd = 32'd0;
    endcase
    check("R3", "pnl_cs_n", 32'(pnl_cs_n), 32'(e_cs));
    check("R4", "pnl_wr_n", 32'(pnl_wr_n), 32'(!(strobe && !m_rd)));
    check("R8", "pnl_rd_n", 32'(pnl_rd_n), 32'(!(strobe && m_rd)));
    check("R2", "pnl_rs",   32'(pnl_rs),   32'(m_act && m_rs));
    check("R10", "pnl_doe", 32'(pnl_doe),  32'(m_act && !m_rd));
    check("R10", "pnl_dout", 32'(pnl_dout), (m_act && !m_rd) ? 32'(m_dat) : 32'd0);
    if (reg_addr == 3'd1)      check("R9", "read result", reg_rdata, e_rd);
    else if (reg_addr == 3'd4) check("R5", "status", reg_rdata, e_rd);
    else                       check("R4", "readback", reg_rdata, e_rd);
  end

  // Panel input changes every clock so the sampled clock is visible
  always @(posedge clk) begin
    #1 pnl_din <= 16'(cyc * 37 + 5);
  end

  // ---------------- stimulus ----------------
  task automatic host_wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0; reg_addr = idle_addr;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_act) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(4);
    // R1: reset state
    @(negedge clk);
    check("R1", "cs_n after reset", 32'(pnl_cs_n), 32'd3);
    check("R1", "strobes after reset", 32'({pnl_wr_n, pnl_rd_n}), 32'd3);
    check("R1", "doe after reset", 32'(pnl_doe), 32'd0);
    check("R1", "status after reset", reg_rdata, 32'd0);
    idle_addr = 3'd1; reg_addr = 3'd1;
    @(negedge clk);
    check("R1", "read result after reset", reg_rdata, 32'd0);
    idle_addr = 3'd4;

    // R2/R3/R4: index write on main, then data write on sub
    host_wr(3'd5, 32'h0001_0201);
    host_wr(3'd0, 32'h1000_00A5);
    host_wr(3'd2, 32'h0000_0001);
    @(negedge clk);
    check("R5", "busy after trigger", reg_rdata, 32'd2);
    wait_idle();
    host_wr(3'd0, 32'h1100_1234);
    host_wr(3'd2, 32'h0000_0003);
    // R10: rewrite word and timing mid-cycle; R6: trigger while busy
    host_wr(3'd0, 32'h1100_FFFF);
    host_wr(3'd5, 32'h000F_0F0F);
    host_wr(3'd2, 32'h0000_0001);
    wait_idle();
    @(negedge clk);
    check("R6", "cs_n after busy trigger", 32'(pnl_cs_n), 32'd3);

    // R4: all-zero timing, single-clock phases
    host_wr(3'd5, 32'h0000_0000);
    host_wr(3'd2, 32'h0000_0001);
    wait_idle();

    // R7: ignored triggers
    host_wr(3'd2, 32'h0000_0002);
    @(negedge clk);
    check("R7", "go bit clear", 32'(pnl_cs_n), 32'd3);
    host_wr(3'd0, 32'h0100_4321);
    host_wr(3'd2, 32'h0000_0001);
    @(negedge clk);
    check("R7", "word tag 28 clear", 32'(pnl_cs_n), 32'd3);
    host_wr(3'd1, 32'h0000_0000);
    host_wr(3'd3, 32'h0000_0001);
    @(negedge clk);
    check("R7", "read request tag clear", 32'(pnl_cs_n), 32'd3);

    // R8/R9: reads on both channels
    host_wr(3'd5, 32'h0002_0301);
    host_wr(3'd1, 32'h0100_0000);
    host_wr(3'd3, 32'h0000_0001);
    wait_idle();
    idle_addr = 3'd1;
    host_wr(3'd3, 32'h0000_0003);
    wait_idle();
    idle(2);
    idle_addr = 3'd4;

    // R6: trigger on final hold clock is dropped, next clock accepted
    host_wr(3'd0, 32'h1000_0055);
    host_wr(3'd2, 32'h0000_0001);
    @(posedge clk); #1;
    while (!(m_act && m_t == m_S + m_P + m_H + 2)) begin
      @(posedge clk); #1;
    end
    reg_we = 1'b1; reg_addr = 3'd2; reg_wdata = 32'h0000_0003;
    @(posedge clk); #1;
    reg_we = 1'b0; reg_addr = 3'd4;
    @(negedge clk);
    check("R6", "last-hold trigger dropped", reg_rdata, 32'd0);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = 3'd2; reg_wdata = 32'h0000_0003;
    @(posedge clk); #1;
    reg_we = 1'b0; reg_addr = 3'd4;
    @(negedge clk);
    check("R3", "sub selected after idle trigger", 32'(pnl_cs_n), 32'd1);
    wait_idle();

    // Mixed traffic
    for (int i = 0; i < 600; i++) begin
      int op;
      op = int'($urandom % 9);
      idle_addr = 3'($urandom % 8);
      case (op)
        0: host_wr(3'd0, {3'd0, ($urandom % 5) != 0, 3'd0, 1'($urandom), 8'd0, 16'($urandom)});
        1: host_wr(3'd5, {12'd0, 4'($urandom % 4), 4'd0, 4'($urandom % 4), 4'd0, 4'($urandom % 4)});
        2, 3, 4: host_wr(3'd2, {30'd0, 1'($urandom), ($urandom % 6) != 0});
        5: host_wr(3'd1, {7'd0, ($urandom % 4) != 0, 24'd0});
        6, 7: host_wr(3'd3, {30'd0, 1'($urandom), ($urandom % 6) != 0});
        default: idle(int'($urandom % 6) + 1);
      endcase
    end
    wait_idle();
    idle(3);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL R5 watchdog: actual still running, expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule